// File: doc/BRIEF.md
# Persistent Overhead Byte Monitor

This block watches one 8-bit user-channel byte taken from the path overhead. The byte arrives once per frame and comes with a one-cycle frame strobe. The block filters out transient corruption: a new byte value is accepted only after the identical pattern has been seen on a programmable number of consecutive frames. The block holds two values, the value accepted most recently and the value accepted before that one.

Whenever the accepted value changes, a sticky change flag is raised. The host clears this flag with a one-cycle clear pulse. The flag drives an interrupt line through a mask. Frame alignment, extraction of the byte from the payload and register decoding are handled outside this block. The host supplies the persistence count, the mask and the clear pulse as plain inputs.

Top module: `ovh_persist_mon`

## Requirements
- R1: `acc_val` changes only as the result of a cycle with `frame_stb` high. It takes that strobe's byte on the next clock edge, and only when that byte is the last of N consecutive strobes that all carried the same byte.
- R2: N equals `persist_n` for values 3 to 15. The values 0, 1 and 2 behave as N = 3.
- R3: All 8 bits are compared. A strobe whose byte differs from the byte of the previous strobe in any bit starts a new run of length 1 on the new byte.
- R4: Whenever `acc_val` is updated, `old_val` takes the value `acc_val` held just before the update.
- R5: A run that reaches N on a byte equal to the current `acc_val` changes neither `acc_val`, nor `old_val`, nor `chg_flag`.
- R6: `chg_flag` goes to 1 on the same clock edge on which `acc_val` changes. It stays at 1 until it is cleared.
- R7: When `chg_clr` is high in a cycle with no update, `chg_flag` reads 0 after the next edge. When a clear and an update fall in the same cycle, the flag stays at 1.
- R8: `chg_irq` equals `chg_flag` while `irq_mask` is 0, and it is 0 while `irq_mask` is 1.
- R9: After reset, `acc_val` and `old_val` are 0x00, `chg_flag` is 0 and no run is in progress.
- R10: The run length saturates at 15. A stable byte held for any number of frames causes no further update and no new flag, and the run count does not wrap.
- R11: Cycles with `frame_stb` low leave the run untouched, whatever is on `byte_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse marking the frame's byte on `byte_in` |
| byte_in | input | 8 | Received overhead byte |
| persist_n | input | 4 | Required number of identical frames (3 to 15) |
| irq_mask | input | 1 | 1 blocks the interrupt output |
| chg_clr | input | 1 | One-cycle clear of the change flag |
| acc_val | output | 8 | Currently accepted byte |
| old_val | output | 8 | Previously accepted byte |
| chg_flag | output | 1 | Sticky change flag |
| chg_irq | output | 1 | Masked interrupt |

## Verification
Two functions can fall in the same cycle: the host clear of the change flag and the setting of the flag by a new acceptance. The bench provokes this by raising `chg_clr` on exactly the strobe that completes an N-frame run on a fresh byte while the flag is already set. It judges that the flag is still 1 afterwards, and that a lone clear one cycle later does take it to 0. A second coincidence is a byte that differs in a single bit arriving on the strobe that would otherwise complete a run. The bench checks that this restarts the count instead of producing an acceptance.

// File: rtl/ovhmon_pkg.sv
package ovhmon_pkg;
    parameter int BYTE_W      = 8;
    parameter int CNT_W       = 4;
    parameter int MIN_PERSIST = 3;

    // Effective persistence: values below the floor act as the floor.
    function automatic logic [CNT_W-1:0] clamp_persist(input logic [CNT_W-1:0] n);
        if (n < CNT_W'(MIN_PERSIST))
            clamp_persist = CNT_W'(MIN_PERSIST);
        else
            clamp_persist = n;
    endfunction
endpackage

// File: rtl/ovhmon_run_tracker.sv
module ovhmon_run_tracker #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  cand_nxt,
    output logic [CW-1:0] run_nxt
);
    localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [W-1:0]  cand;
        logic [CW-1:0] run;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (stb) begin
            if (trk_q.run == '0 || din != trk_q.cand) begin
                trk_d.cand = din;
                trk_d.run  = CW'(1);
            end else if (trk_q.run != RUN_MAX) begin
                trk_d.run = trk_q.run + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            trk_q <= '0;
        else
            trk_q <= trk_d;
    end

    assign cand_nxt = trk_d.cand;
    assign run_nxt  = trk_d.run;
endmodule

// File: rtl/ovhmon_history.sv
module ovhmon_history #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic [W-1:0] cand,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev,
    output logic         upd
);
    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } hist_t;

    hist_t hist_d, hist_q;
    logic  upd_c;

    always_comb begin
        hist_d = hist_q;
        upd_c  = hit && (cand != hist_q.cur);
        if (upd_c) begin
            hist_d.prev = hist_q.cur;
            hist_d.cur  = cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist_q <= '0;
        else
            hist_q <= hist_d;
    end

    assign cur  = hist_q.cur;
    assign prev = hist_q.prev;
    assign upd  = upd_c;
endmodule

// File: rtl/ovhmon_delta_irq.sv
module ovhmon_delta_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic mask,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic flag;
    } dl_t;

    dl_t dl_d, dl_q;

    always_comb begin
        dl_d = dl_q;
        if (set)
            dl_d.flag = 1'b1;
        else if (clr)
            dl_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dl_q <= '0;
        else
            dl_q <= dl_d;
    end

    assign flag = dl_q.flag;
    assign irq  = dl_q.flag & ~mask;
endmodule

// File: rtl/ovh_persist_mon.sv
module ovh_persist_mon
    import ovhmon_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_stb,
    input  logic [W-1:0]  byte_in,
    input  logic [CW-1:0] persist_n,
    input  logic          irq_mask,
    input  logic          chg_clr,
    output logic [W-1:0]  acc_val,
    output logic [W-1:0]  old_val,
    output logic          chg_flag,
    output logic          chg_irq
);
    logic [W-1:0]  cand_nxt;
    logic [CW-1:0] run_nxt;
    logic [CW-1:0] n_eff;
    logic          hit;
    logic          upd;

    assign n_eff = (persist_n < CW'(MIN_PERSIST)) ? CW'(MIN_PERSIST) : persist_n;
    assign hit   = frame_stb && (run_nxt >= n_eff);

    ovhmon_run_tracker #(.W(W), .CW(CW)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (frame_stb),
        .din      (byte_in),
        .cand_nxt (cand_nxt),
        .run_nxt  (run_nxt)
    );

    ovhmon_history #(.W(W)) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .cand  (cand_nxt),
        .cur   (acc_val),
        .prev  (old_val),
        .upd   (upd)
    );

    ovhmon_delta_irq u_dl (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (upd),
        .clr   (chg_clr),
        .mask  (irq_mask),
        .flag  (chg_flag),
        .irq   (chg_irq)
    );
endmodule

// File: rtl/ovhmon_chk.sv
module ovhmon_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_stb,
    input logic         chg_clr,
    input logic         irq_mask,
    input logic [W-1:0] acc_val,
    input logic [W-1:0] old_val,
    input logic         chg_flag,
    input logic         chg_irq
);
    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(acc_val) && $stable(old_val))); // R1

    AST_HISTORY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_val != $past(acc_val)) |-> (old_val == $past(acc_val))); // R4

    AST_FLAG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_val != $past(acc_val)) |-> chg_flag); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_flag && !chg_clr) |=> chg_flag); // R6

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_clr && !frame_stb) |=> !chg_flag); // R7

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !chg_irq); // R8

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        chg_irq |-> chg_flag); // R8
endmodule

bind ovh_persist_mon ovhmon_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .chg_clr   (chg_clr),
    .irq_mask  (irq_mask),
    .acc_val   (acc_val),
    .old_val   (old_val),
    .chg_flag  (chg_flag),
    .chg_irq   (chg_irq)
);

// File: tb/tb_ovh_persist_mon.sv
module tb_ovh_persist_mon;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic [7:0] byte_in = '0;
    logic [3:0] persist_n = 4'd3;
    logic       irq_mask = 1'b0;
    logic       chg_clr = 1'b0;
    logic [7:0] acc_val, old_val;
    logic       chg_flag, chg_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_cand = 0, m_run = 0, m_cur = 0, m_prev = 0, m_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovh_persist_mon dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .byte_in(byte_in),
        .persist_n(persist_n), .irq_mask(irq_mask), .chg_clr(chg_clr),
        .acc_val(acc_val), .old_val(old_val), .chg_flag(chg_flag), .chg_irq(chg_irq)
    );

    always @(posedge clk or negedge rst_n) begin
        int need;
        bit set;
        if (!rst_n) begin
            m_cand = 0; m_run = 0; m_cur = 0; m_prev = 0; m_flag = 0;
        end else begin
            set  = 0;
            need = (persist_n < 3) ? 3 : int'(persist_n);
            if (frame_stb) begin
                if (m_run == 0 || int'(byte_in) != m_cand) begin
                    m_cand = byte_in;
                    m_run  = 1;
                end else if (m_run < 15) begin
                    m_run++;
                end
                if (m_run >= need && m_cand != m_cur) begin
                    m_prev = m_cur;
                    m_cur  = m_cand;
                    set    = 1;
                end
            end
            if (set) m_flag = 1;
            else if (chg_clr) m_flag = 0;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "acc_val", acc_val, m_cur);
        chk(tag, "old_val", old_val, m_prev);
        chk(tag, "chg_flag", chg_flag, m_flag);
        chk(tag, "chg_irq", chg_irq, (m_flag != 0 && !irq_mask) ? 1 : 0);
    endtask

    // one cycle: compare at the falling edge, then drive the next inputs
    task automatic step(string tag, bit stb, logic [7:0] b, bit clr);
        @(negedge clk);
        compare(tag);
        frame_stb = stb;
        byte_in   = b;
        chg_clr   = clr;
    endtask

    task automatic frames(string tag, logic [7:0] b, int cnt);
        for (int i = 0; i < cnt; i++) begin
            step(tag, 1'b1, b, 1'b0);
            step(tag, 1'b0, ~b, 1'b0);   // R11: byte_in toggles between strobes
        end
    endtask

    task automatic idle(string tag, int cnt);
        for (int i = 0; i < cnt; i++) step(tag, 1'b0, 8'hEE, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", "acc_val reset", acc_val, 0);
        chk("R9", "old_val reset", old_val, 0);
        chk("R9", "chg_flag reset", chg_flag, 0);
        rst_n = 1'b1;
        idle("R9", 2);

        // R1: N=3 acceptance
        persist_n = 4'd3;
        frames("R1", 8'h5A, 2);
        idle("R1", 1);
        chk("R1", "not yet accepted", acc_val, 8'h00);
        frames("R1", 8'h5A, 1);
        idle("R1", 1);
        chk("R1", "accepted after 3", acc_val, 8'h5A);
        chk("R6", "flag set", chg_flag, 1);

        // R7: lone clear
        step("R7", 1'b0, 8'h00, 1'b1);
        idle("R7", 1);
        chk("R7", "flag cleared", chg_flag, 0);

        // R3: single-bit difference restarts run, N=5
        persist_n = 4'd5;
        frames("R3", 8'hC3, 4);
        frames("R3", 8'hC2, 1);
        frames("R3", 8'hC3, 4);
        idle("R3", 1);
        chk("R3", "restarted run held", acc_val, 8'h5A);
        frames("R3", 8'hC3, 1);
        idle("R4", 1);
        chk("R3", "accepted after restart", acc_val, 8'hC3);
        chk("R4", "history shift", old_val, 8'h5A);

        // R2: values below 3 behave as 3
        persist_n = 4'd0;
        frames("R2", 8'h11, 2);
        idle("R2", 1);
        chk("R2", "2 frames insufficient", acc_val, 8'hC3);
        frames("R2", 8'h11, 1);
        idle("R2", 1);
        chk("R2", "accepted with N=0", acc_val, 8'h11);
        persist_n = 4'd2;
        frames("R2", 8'h22, 3);
        idle("R2", 1);
        chk("R2", "accepted with N=2", acc_val, 8'h22);

        // R2: N=15
        persist_n = 4'd15;
        frames("R2", 8'h7E, 14);
        idle("R2", 1);
        chk("R2", "14 of 15", acc_val, 8'h22);
        frames("R2", 8'h7E, 1);
        idle("R2", 1);
        chk("R2", "15 of 15", acc_val, 8'h7E);

        // R10: long stable run, then clear and watch flag stays low
        step("R10", 1'b0, 8'h00, 1'b1);
        frames("R10", 8'h7E, 40);
        idle("R10", 1);
        chk("R10", "no re-update flag", chg_flag, 0);
        chk("R10", "value steady", acc_val, 8'h7E);

        // R5: run on the value already accepted
        persist_n = 4'd3;
        frames("R5", 8'h33, 2);
        frames("R5", 8'h7E, 5);
        idle("R5", 1);
        chk("R5", "acc unchanged", acc_val, 8'h7E);
        chk("R5", "old unchanged", old_val, 8'h22);
        chk("R5", "flag unchanged", chg_flag, 0);

        // R8: mask
        frames("R8", 8'h44, 3);
        idle("R8", 1);
        chk("R8", "irq unmasked", chg_irq, 1);
        irq_mask = 1'b1;
        idle("R8", 1);
        chk("R8", "irq masked", chg_irq, 0);
        irq_mask = 1'b0;
        idle("R8", 1);

        // R7: clear and set in the same cycle, flag already set
        frames("R7", 8'h99, 2);
        step("R7", 1'b1, 8'h99, 1'b1);
        step("R7", 1'b0, 8'h00, 1'b0);
        @(negedge clk);
        chk("R7", "set wins over clear", chg_flag, 1);
        chk("R7", "value on coincidence", acc_val, 8'h99);
        step("R7", 1'b0, 8'h00, 1'b1);
        step("R7", 1'b0, 8'h00, 1'b0);
        @(negedge clk);
        chk("R7", "clear after coincidence", chg_flag, 0);

        // R11: strobes separated by long gaps with noise
        for (int k = 0; k < 3; k++) begin
            step("R11", 1'b1, 8'hA5, 1'b0);
            for (int j = 0; j < 4; j++) step("R11", 1'b0, 8'(j * 37), 1'b0);
        end
        idle("R11", 1);
        chk("R11", "noise ignored", acc_val, 8'hA5);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule